// File: doc/BRIEF.md
# NAND Pin-Level Bridge with Running ECC

This block sits on a simple processor bus and lets software operate a raw 8-bit NAND flash device directly at the pin level. Software sets the command-latch, address-latch, chip-enable and write-protect lines through a pin register. It moves single bytes to or from the flash through a transfer register. Each byte transfer pulses the flash write or read strobe for a fixed number of clocks. The bus acknowledge is held back until the strobe has finished.

Every byte that crosses the transfer register, in either direction, is folded into a running parity accumulator. Software reads back three values: the number of bytes folded in since the last clear, a six-bit column parity and a 32-bit word that interleaves two 16-bit line-parity words. From these it computes or checks a Hamming-style ECC for a page. Writing zero to the count register starts a new page.

The bus side uses a one-cycle request pulse and a one-cycle acknowledge. The flash side is a plain pin bus with separate data-in and data-out lanes and an output enable.

Top module: `nandb_bridge`

## Requirements
- R1: The register is selected by the word index `bus_addr[11:2]`. Index 0 is IDENT, 1 is XFER, 2 is PINS, 3 is ECNT, 4 is ECOL and 5 is ELINE.
- R2: A read of IDENT returns the parameter `ID_VALUE` (default 0x4E414E44).
- R3: A write to PINS stores `bus_wdata[3:0]` and discards the other bits. Bit 0 drives `flash_cmd_latch`, bit 1 drives `flash_addr_latch`, bit 2 drives `flash_chip_en` and bit 3 drives `flash_wr_prot`. The stored value holds until the next PINS write.
- R4: A read of PINS returns the stored bits in [3:0]. Bit 4 is `flash_rdy` after a two-flop synchronizer, where 1 means ready. Bits [31:5] read as zero.
- R5: A write to XFER puts `bus_wdata[7:0]` on `flash_dout`. It raises `flash_doe` and `flash_wr_stb` for `STROBE_CYC` clocks (default 3). `bus_ack` follows in the next cycle with read data 0 and no error.
- R6: A read of XFER raises `flash_rd_stb` for `STROBE_CYC` clocks. It samples `flash_din` in the last strobe cycle and returns that byte in `bus_rdata[7:0]`, with the upper bits zero.
- R7: Every byte transferred through XFER increments the byte count. A read of ECNT returns the count, zero-extended.
- R8: A read of ECOL returns six bits. Each bit is the XOR, over all bytes since the clear, of the parity of a masked byte:
  - bit 0 uses mask 0x55;
  - bit 1 uses mask 0xAA;
  - bit 2 uses mask 0x33;
  - bit 3 uses mask 0xCC;
  - bit 4 uses mask 0x0F;
  - bit 5 uses mask 0xF0.
- R9: For each byte with an odd number of ones, line word B is XORed with the byte's index, and line word A is XORed with the 16-bit complement of that index. The index is the count before the increment. A read of ELINE returns word A bit n at bit 2n and word B bit n at bit 2n+1. Bytes with even parity leave both words unchanged.
- R10: Any write to ECNT clears the count, the column parity and both line words. A nonzero written value also raises `bus_err` with the acknowledge.
- R11: A read of an unmapped index (6 and up) returns 0 with `bus_err`. A write to an unmapped index, or to IDENT, ECOL or ELINE, changes nothing and raises `bus_err`.
- R12: `bus_req` is a one-cycle pulse and is accepted only when the bridge is idle. A register access acknowledges in the cycle after acceptance. `bus_ack` lasts one cycle. `bus_rdata` and `bus_err` are zero whenever `bus_ack` is low.
- R13: Reset clears the pin register, the strobes, the output enable and the whole accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req | input | 1 | One-cycle access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Word address bits [11:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | Access complete |
| bus_err | output | 1 | Access error, valid with bus_ack |
| flash_cmd_latch | output | 1 | Command latch enable pin |
| flash_addr_latch | output | 1 | Address latch enable pin |
| flash_chip_en | output | 1 | Chip enable pin |
| flash_wr_prot | output | 1 | Write protect pin |
| flash_dout | output | 8 | Byte driven toward the flash |
| flash_doe | output | 1 | Output enable for flash_dout |
| flash_din | input | 8 | Byte from the flash |
| flash_wr_stb | output | 1 | Write strobe |
| flash_rd_stb | output | 1 | Read strobe |
| flash_rdy | input | 1 | Ready/busy pin, 1 = ready |

## Verification
The bench mixes writes and reads of bytes with odd and with even parity. It then compares the count, the column parity and the interleaved line word against its own model. A design that swapped the two line words, skipped read-direction bytes or indexed after the increment would miss that comparison.

It measures the strobe width and the acknowledge latency. A timer that is off by one shows up as a wrong cycle count.

It writes pin values with junk in the upper bits. It also drives the ready pin low and then high, so that a missing mask or a wrong ready polarity shows up at the pins.

Error cases are probed through the ports:
- a nonzero clear value that must still clear the accumulator;
- writes to read-only and unmapped indices, which must leave the pins and parity untouched;
- a reset in the middle of a run.

// File: rtl/nandb_pkg.sv
package nandb_pkg;

    localparam int BUS_W = 32;
    localparam int IDX_W = 10;
    localparam int LP_W  = 16;
    localparam int RDY_BIT = 4;

    localparam logic [IDX_W-1:0] IDX_IDENT = 10'd0;
    localparam logic [IDX_W-1:0] IDX_XFER  = 10'd1;
    localparam logic [IDX_W-1:0] IDX_PINS  = 10'd2;
    localparam logic [IDX_W-1:0] IDX_ECNT  = 10'd3;
    localparam logic [IDX_W-1:0] IDX_ECOL  = 10'd4;
    localparam logic [IDX_W-1:0] IDX_ELINE = 10'd5;

    typedef struct packed {
        logic wr_prot;
        logic chip_en;
        logic addr_latch;
        logic cmd_latch;
    } pins_t;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_STROBE = 2'd1,
        SQ_DONE   = 2'd2
    } seq_e;

    typedef struct packed {
        logic             wr;
        logic [IDX_W-1:0] idx;
        logic [BUS_W-1:0] data;
    } bus_cmd_t;

    typedef struct packed {
        logic [BUS_W-1:0] rdata;
        logic             err;
    } reg_resp_t;

    // Six group parities of one byte: even bits, odd bits, two pair groups, two nibbles.
    function automatic logic [5:0] col_groups(input logic [7:0] b);
        logic [5:0] g;
        g[0] = ^(b & 8'h55);
        g[1] = ^(b & 8'hAA);
        g[2] = ^(b & 8'h33);
        g[3] = ^(b & 8'hCC);
        g[4] = ^(b & 8'h0F);
        g[5] = ^(b & 8'hF0);
        return g;
    endfunction

    // Word A lands on even bit positions, word B on odd ones.
    function automatic logic [2*LP_W-1:0] lp_weave(input logic [LP_W-1:0] wa,
                                                    input logic [LP_W-1:0] wb);
        logic [2*LP_W-1:0] r;
        for (int n = 0; n < LP_W; n++) begin
            r[2*n]   = wa[n];
            r[2*n+1] = wb[n];
        end
        return r;
    endfunction

endpackage

// File: rtl/nandb_ecc.sv
module nandb_ecc
    import nandb_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             dig,
    input  logic [7:0]       din,
    output logic [CNT_W-1:0] cnt,
    output logic [5:0]       colp,
    output logic [LP_W-1:0]  lpa,
    output logic [LP_W-1:0]  lpb
);

    logic [LP_W-1:0] idx;

    generate
        if (CNT_W >= LP_W) begin : g_idx_trunc
            assign idx = cnt[LP_W-1:0];
        end else begin : g_idx_ext
            assign idx = {{(LP_W-CNT_W){1'b0}}, cnt};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt  <= '0;
            colp <= '0;
            lpa  <= '0;
            lpb  <= '0;
        end else if (dig) begin
            cnt  <= cnt + CNT_W'(1);
            colp <= colp ^ col_groups(din);
            if (^din) begin
                lpb <= lpb ^ idx;
                lpa <= lpa ^ ~idx;
            end
        end
    end

    AST_CLR_DIG_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(clr && dig)); // R10

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        dig |=> cnt == $past(cnt) + CNT_W'(1)); // R7

    AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0) && (colp == '0) && (lpa == '0) && (lpb == '0)); // R10

    AST_EVEN_KEEPS_LP: assert property (@(posedge clk) disable iff (rst)
        (dig && !(^din)) |=> $stable(lpa) && $stable(lpb)); // R9

endmodule

// File: rtl/nandb_pins.sv
module nandb_pins
    import nandb_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [3:0] wbits,
    input  logic       rdy_async,
    output pins_t      pins,
    output logic       rdy_sync
);

    logic [SYNC_STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst)
            pins <= '0;
        else if (load)
            pins <= pins_t'(wbits);
    end

    generate
        if (SYNC_STAGES < 2) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= rdy_async;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[SYNC_STAGES-2:0], rdy_async};
            end
        end
    endgenerate

    assign rdy_sync = sh[SYNC_STAGES-1];

    AST_PINS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(pins)); // R3

    AST_PINS_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> pins == pins_t'($past(wbits))); // R3

endmodule

// File: rtl/nandb_seq.sv
module nandb_seq
    import nandb_pkg::*;
#(
    parameter int STROBE_CYC = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req,
    input  logic       is_xfer,
    input  logic       wr,
    input  logic [7:0] wbyte,
    input  logic [7:0] din,
    output logic       reg_go,
    output logic       xfer_go,
    output logic       ack,
    output logic       wr_stb,
    output logic       rd_stb,
    output logic       doe,
    output logic [7:0] dout,
    output logic       byte_done,
    output logic [7:0] byte_val
);

    localparam int TMR_W = (STROBE_CYC > 1) ? $clog2(STROBE_CYC) : 1;

    seq_e             st;
    logic [TMR_W-1:0] tmr;
    logic             dir_wr;

    assign reg_go  = (st == SQ_IDLE) && req && !is_xfer;
    assign xfer_go = (st == SQ_IDLE) && req && is_xfer;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= SQ_IDLE;
            tmr    <= '0;
            dir_wr <= 1'b0;
            dout   <= '0;
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (xfer_go) begin
                        st     <= SQ_STROBE;
                        tmr    <= TMR_W'(STROBE_CYC - 1);
                        dir_wr <= wr;
                        if (wr) dout <= wbyte;
                    end else if (reg_go) begin
                        st <= SQ_DONE;
                    end
                end
                SQ_STROBE: begin
                    if (tmr == '0) st  <= SQ_DONE;
                    else           tmr <= tmr - TMR_W'(1);
                end
                SQ_DONE:  st <= SQ_IDLE;
                default:  st <= SQ_IDLE;
            endcase
        end
    end

    assign wr_stb    = (st == SQ_STROBE) && dir_wr;
    assign rd_stb    = (st == SQ_STROBE) && !dir_wr;
    assign doe       = wr_stb;
    assign byte_done = (st == SQ_STROBE) && (tmr == '0);
    assign byte_val  = dir_wr ? dout : din;
    assign ack       = (st == SQ_DONE);

    AST_STB_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(wr_stb && rd_stb)); // R5

    AST_ACK_ONE: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack); // R12

    AST_STB_HOLD: assert property (@(posedge clk) disable iff (rst)
        ((wr_stb || rd_stb) && !byte_done) |=> (wr_stb || rd_stb)); // R5

    AST_DOUT_STABLE: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !byte_done) |=> $stable(dout)); // R5

    AST_STB_THEN_ACK: assert property (@(posedge clk) disable iff (rst)
        byte_done |=> ack); // R6

endmodule

// File: rtl/nandb_bridge.sv
module nandb_bridge
    import nandb_pkg::*;
#(
    parameter int          STROBE_CYC  = 3,
    parameter int          CNT_W       = 16,
    parameter int          SYNC_STAGES = 2,
    parameter logic [31:0] ID_VALUE    = 32'h4E41_4E44
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_req,
    input  logic        bus_wr,
    input  logic [11:2] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        bus_ack,
    output logic        bus_err,
    output logic        flash_cmd_latch,
    output logic        flash_addr_latch,
    output logic        flash_chip_en,
    output logic        flash_wr_prot,
    output logic [7:0]  flash_dout,
    output logic        flash_doe,
    input  logic [7:0]  flash_din,
    output logic        flash_wr_stb,
    output logic        flash_rd_stb,
    input  logic        flash_rdy
);

    bus_cmd_t         cmd;
    reg_resp_t        resp;
    pins_t            pins;
    logic             rdy_sync;
    logic             reg_go, xfer_go, ack, byte_done;
    logic [7:0]       byte_val;
    logic [CNT_W-1:0] cnt;
    logic [5:0]       colp;
    logic [LP_W-1:0]  lpa, lpb;
    logic [31:0]      rdata_q;
    logic             err_q;

    assign cmd = '{wr: bus_wr, idx: bus_addr, data: bus_wdata};

    nandb_seq #(.STROBE_CYC(STROBE_CYC)) u_seq (
        .clk(clk), .rst(rst), .req(bus_req),
        .is_xfer(cmd.idx == IDX_XFER), .wr(cmd.wr),
        .wbyte(cmd.data[7:0]), .din(flash_din),
        .reg_go(reg_go), .xfer_go(xfer_go), .ack(ack),
        .wr_stb(flash_wr_stb), .rd_stb(flash_rd_stb), .doe(flash_doe),
        .dout(flash_dout), .byte_done(byte_done), .byte_val(byte_val)
    );

    nandb_pins #(.SYNC_STAGES(SYNC_STAGES)) u_pins (
        .clk(clk), .rst(rst),
        .load(reg_go && cmd.wr && (cmd.idx == IDX_PINS)),
        .wbits(cmd.data[3:0]), .rdy_async(flash_rdy),
        .pins(pins), .rdy_sync(rdy_sync)
    );

    nandb_ecc #(.CNT_W(CNT_W)) u_ecc (
        .clk(clk), .rst(rst),
        .clr(reg_go && cmd.wr && (cmd.idx == IDX_ECNT)),
        .dig(byte_done), .din(byte_val),
        .cnt(cnt), .colp(colp), .lpa(lpa), .lpb(lpb)
    );

    always_comb begin
        resp = '0;
        case (cmd.idx)
            IDX_IDENT: begin resp.rdata = ID_VALUE; resp.err = cmd.wr; end
            IDX_PINS: begin
                resp.rdata[3:0]     = pins;
                resp.rdata[RDY_BIT] = rdy_sync;
            end
            IDX_ECNT: begin
                resp.rdata = 32'(cnt);
                resp.err   = cmd.wr && (cmd.data != '0);
            end
            IDX_ECOL:  begin resp.rdata = 32'(colp); resp.err = cmd.wr; end
            IDX_ELINE: begin resp.rdata = lp_weave(lpa, lpb); resp.err = cmd.wr; end
            default:   resp.err = 1'b1;
        endcase
        if (cmd.wr) resp.rdata = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else if (reg_go) begin
            rdata_q <= resp.rdata;
            err_q   <= resp.err;
        end else if (xfer_go) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else if (byte_done && flash_rd_stb) begin
            rdata_q <= {24'b0, byte_val};
        end
    end

    assign bus_ack          = ack;
    assign bus_rdata        = ack ? rdata_q : '0;
    assign bus_err          = ack & err_q;
    assign flash_cmd_latch  = pins.cmd_latch;
    assign flash_addr_latch = pins.addr_latch;
    assign flash_chip_en    = pins.chip_en;
    assign flash_wr_prot    = pins.wr_prot;

    AST_REG_ACK_NEXT: assert property (@(posedge clk) disable iff (rst)
        reg_go |=> bus_ack); // R12

    AST_XFER_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        byte_done |=> !bus_err); // R5

    AST_RD_ZERO_EXT: assert property (@(posedge clk) disable iff (rst)
        (byte_done && flash_rd_stb) |=> bus_rdata[31:8] == '0); // R6

endmodule

// File: tb/tb_nandb_bridge.sv
module tb_nandb_bridge;

    localparam int          S      = 3;
    localparam logic [31:0] ID_EXP = 32'h4E41_4E44;
    localparam int          NV     = 12;
    // entry: kind[41:40] (0 pins write, 1 byte write, 2 byte read), value[39:8], expected[7:0]
    localparam logic [41:0] VEC [NV] = '{
        {2'd0, 32'h0000_0005, 8'h05},
        {2'd1, 32'h0000_0090, 8'h90},
        {2'd0, 32'hFFFF_FFF6, 8'h06},
        {2'd1, 32'h1234_5601, 8'h01},
        {2'd2, 32'h0000_00EC, 8'hEC},
        {2'd2, 32'h0000_0000, 8'h00},
        {2'd0, 32'h0000_000B, 8'h0B},
        {2'd1, 32'h0000_00FF, 8'hFF},
        {2'd2, 32'h0000_007F, 8'h7F},
        {2'd1, 32'h0000_0080, 8'h80},
        {2'd2, 32'h0000_003C, 8'h3C},
        {2'd0, 32'h0000_0004, 8'h04}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_req = 1'b0, bus_wr = 1'b0;
    logic [11:2] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ack, bus_err;
    logic        f_cle, f_ale, f_ce, f_wp;
    logic [7:0]  f_dout;
    logic        f_doe, f_wstb, f_rstb;
    logic [7:0]  f_din = '0;
    logic        f_rdy = 1'b0;

    int n_chk = 0;
    int n_err = 0;

    logic [15:0] m_cnt;
    logic [5:0]  m_colp;
    logic [15:0] m_lpa, m_lpb;

    always #4 clk = ~clk;

    nandb_bridge dut (
        .clk(clk), .rst(rst), .bus_req(bus_req), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ack(bus_ack), .bus_err(bus_err),
        .flash_cmd_latch(f_cle), .flash_addr_latch(f_ale),
        .flash_chip_en(f_ce), .flash_wr_prot(f_wp),
        .flash_dout(f_dout), .flash_doe(f_doe), .flash_din(f_din),
        .flash_wr_stb(f_wstb), .flash_rd_stb(f_rstb), .flash_rdy(f_rdy)
    );

    task automatic check(input string rq, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic logic [3:0] pin_vec();
        return {f_wp, f_ce, f_ale, f_cle};
    endfunction

    task automatic model_clear();
        m_cnt = '0; m_colp = '0; m_lpa = '0; m_lpb = '0;
    endtask

    task automatic model_byte(input logic [7:0] b);
        logic [7:0] masks [6] = '{8'h55, 8'hAA, 8'h33, 8'hCC, 8'h0F, 8'hF0};
        int ones = 0;
        for (int k = 0; k < 6; k++) begin
            int c = 0;
            for (int j = 0; j < 8; j++) if (masks[k][j] && b[j]) c++;
            if (c % 2 == 1) m_colp[k] = ~m_colp[k];
        end
        for (int j = 0; j < 8; j++) if (b[j]) ones++;
        if (ones % 2 == 1) begin
            m_lpb = m_lpb ^ m_cnt;
            m_lpa = m_lpa ^ (~m_cnt);
        end
        m_cnt = m_cnt + 16'd1;
    endtask

    function automatic logic [31:0] model_line();
        logic [31:0] r;
        for (int n = 0; n < 16; n++) begin
            r[2*n]   = m_lpa[n];
            r[2*n+1] = m_lpb[n];
        end
        return r;
    endfunction

    task automatic bus_op(input logic wr, input logic [9:0] idx, input logic [31:0] wd,
                          output logic [31:0] rd, output logic er,
                          output int lat, output int nstb, output logic [7:0] dseen);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = wr; bus_addr = idx; bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0;
        lat = 1; nstb = 0; dseen = 8'h00;
        while (!bus_ack && lat < 100) begin
            if (f_wstb || f_rstb) nstb++;
            if (f_wstb && f_doe) dseen = f_dout;
            @(negedge clk);
            lat++;
        end
        if (lat >= 100) check("R12", "ack watchdog", 32'(lat), 32'd0);
        rd = bus_rdata; er = bus_err;
    endtask

    task automatic rd_reg(input logic [9:0] idx, input string rq, input string what,
                          input logic [31:0] exp, input logic exp_err);
        logic [31:0] rd; logic er; int lat, ns; logic [7:0] ds;
        bus_op(1'b0, idx, '0, rd, er, lat, ns, ds);
        check(rq, what, rd, exp);
        check(rq, {what, " err"}, 32'(er), 32'(exp_err));
    endtask

    task automatic wr_reg(input logic [9:0] idx, input logic [31:0] wd,
                          input string rq, input logic exp_err);
        logic [31:0] rd; logic er; int lat, ns; logic [7:0] ds;
        bus_op(1'b1, idx, wd, rd, er, lat, ns, ds);
        check(rq, "write err flag", 32'(er), 32'(exp_err));
    endtask

    task automatic xfer_wr(input logic [7:0] b);
        logic [31:0] rd; logic er; int lat, ns; logic [7:0] ds;
        bus_op(1'b1, 10'd1, {24'hA5A5A5, b}, rd, er, lat, ns, ds);
        check("R5", "write strobe cycles", 32'(ns), 32'(S));
        check("R5", "write ack latency", 32'(lat), 32'(S + 1));
        check("R5", "byte on flash_dout", 32'(ds), 32'(b));
        check("R5", "write rdata/err", {rd[30:0], er}, 32'd0);
        model_byte(b);
    endtask

    task automatic xfer_rd(input logic [7:0] b);
        logic [31:0] rd; logic er; int lat, ns; logic [7:0] ds;
        f_din = b;
        bus_op(1'b0, 10'd1, '0, rd, er, lat, ns, ds);
        check("R6", "read strobe cycles", 32'(ns), 32'(S));
        check("R6", "read byte returned", rd, 32'(b));
        check("R6", "read err", 32'(er), 32'd0);
        model_byte(b);
    endtask

    task automatic check_ecc(input string tag);
        rd_reg(10'd3, "R7", {tag, " byte count"}, 32'(m_cnt), 1'b0);
        rd_reg(10'd4, "R8", {tag, " column parity"}, 32'(m_colp), 1'b0);
        rd_reg(10'd5, "R9", {tag, " line parity"}, model_line(), 1'b0);
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL R12 global watchdog expired: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        // R13: reset state at the ports
        check("R13", "pins after reset", 32'(pin_vec()), 32'd0);
        check("R13", "strobes/oe after reset", {29'd0, f_wstb, f_rstb, f_doe}, 32'd0);
        check("R12", "ack/rdata idle", {bus_rdata[30:0], bus_ack}, 32'd0);
        rst = 1'b0;

        check_ecc("after reset R13");
        rd_reg(10'd0, "R2", "ident", ID_EXP, 1'b0);

        // R4: ready polarity through synchronizer
        repeat (4) @(negedge clk);
        rd_reg(10'd2, "R4", "pins busy", 32'h0, 1'b0);
        f_rdy = 1'b1;
        repeat (4) @(negedge clk);
        rd_reg(10'd2, "R4", "pins ready", 32'h10, 1'b0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [41:0] e = VEC[i];
            case (e[41:40])
                2'd0: begin
                    wr_reg(10'd2, e[39:8], "R3", 1'b0);
                    check("R3", "pin outputs", 32'(pin_vec()), 32'(e[3:0]));
                    rd_reg(10'd2, "R4", "pins readback", {27'd0, 1'b1, e[3:0]}, 1'b0);
                end
                2'd1: xfer_wr(e[15:8]);
                default: begin
                    xfer_rd(e[15:8]);
                end
            endcase
        end
        check_ecc("table");

        // R12: ack is one cycle, then rdata/err return to zero
        begin
            logic [31:0] rd; logic er; int lat, ns; logic [7:0] ds;
            bus_op(1'b0, 10'd0, '0, rd, er, lat, ns, ds);
            check("R12", "register ack latency", 32'(lat), 32'd1);
            @(negedge clk);
            check("R12", "ack one cycle", {bus_rdata[30:0], bus_ack}, 32'd0);
        end

        // R1: index decode, PINS at index 2
        wr_reg(10'd2, 32'h3, "R1", 1'b0);
        check("R1", "pins via index 2", 32'(pin_vec()), 32'h3);

        // R11: unmapped and read-only accesses
        rd_reg(10'd6, "R11", "unmapped read", 32'd0, 1'b1);
        rd_reg(10'h3FF, "R11", "top unmapped read", 32'd0, 1'b1);
        wr_reg(10'd7, 32'hF, "R11", 1'b1);
        check("R11", "pins after unmapped write", 32'(pin_vec()), 32'h3);
        wr_reg(10'd0, 32'h0, "R11", 1'b1);
        rd_reg(10'd0, "R11", "ident after write", ID_EXP, 1'b0);
        wr_reg(10'd4, 32'h3F, "R11", 1'b1);
        wr_reg(10'd5, 32'hFFFF_FFFF, "R11", 1'b1);
        check_ecc("after ro writes R11");

        // R10: nonzero clear flags error but still clears
        wr_reg(10'd3, 32'h5, "R10", 1'b1);
        model_clear();
        check_ecc("after clear R10");
        xfer_wr(8'h01);
        rd_reg(10'd5, "R9", "index 0 odd byte", 32'h5555_5555, 1'b0);
        xfer_rd(8'h03);
        check_ecc("even byte R9");
        wr_reg(10'd3, 32'h0, "R10", 1'b0);
        model_clear();
        rd_reg(10'd3, "R10", "count after zero clear", 32'd0, 1'b0);

        // R13: reset in the middle of a run
        wr_reg(10'd2, 32'hF, "R3", 1'b0);
        xfer_wr(8'h07);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        check("R13", "pins after mid reset", 32'(pin_vec()), 32'd0);
        model_clear();
        check_ecc("after mid reset R13");

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule